// File: doc/BRIEF.md
# PCIe Configuration Request Engine

This block lets a host CPU issue PCIe configuration reads and writes one at a time through a small memory-mapped register file. Software writes four things: the request type, a 64-bit target address split over two words, the write data and a byte strobe. It then writes 1 to the start register. The engine takes a snapshot of the request and offers it to a link-side agent on a valid/ready handshake. It then waits for a single completion beat that carries a 3-bit status code and a data word.

When the completion arrives, the engine records the status code and the posted/non-posted class of the finished request. It stores the read data, or all ones if the status is not success. It sets a write-one-to-clear done flag and drops the start bit back to 0. Software polls until start reads 0 and done reads 1, or it relies on the maskable interrupt output. For configuration types the engine enforces the configuration address form: the register offset is dword aligned and the upper address word is zero. For read types it drives a full strobe.

The configuration address fields lie in the low word: bus in bits 27:20, device in bits 19:15, function in bits 14:12 and the dword register offset in bits 11:2. Software places sub-dword write data and strobes itself. The engine passes the data and the strobe unchanged for write types.

Top module: `cfg_pio_engine`

## Requirements
- R1: After synchronous reset every readable register returns 0, req_valid is 0 and irq is 0.
- R2: Register map (byte offsets): 0x00 control, 0x04 status, 0x08 address low, 0x0C address high, 0x10 write data, 0x14 strobe, 0x18 read data, 0x1C start, 0x20 done flag, 0x24 interrupt mask. Control keeps only type bits 3:0 and the window-bypass bit 24. Strobe keeps bits 3:0. Mask and done use bit 0. Unmapped or misaligned addresses read 0. reg_rdata shows the addressed register one clock after the address is presented.
- R3: A write with data bit 0 = 1 to start while idle raises req_valid on the next clock. req_type, req_addr, req_wdata and req_strb stay stable while req_valid is high and req_ready is low, and start reads 1 until the completion.
- R4: For configuration types 0x8, 0x9, 0xA and 0xB, req_addr bits 1:0 and the upper 32 bits are driven as 0. For every other type the 64-bit address {high, low} passes unchanged. Control bit 24 never alters the address.
- R5: For read types 0x8 and 0x9, req_strb is 0xF whatever was programmed. For other types the programmed strobe and write data pass unchanged.
- R6: A start write of 0 or 1 during a request is ignored, and register writes during a request do not alter the request already on the link side.
- R7: cpl_valid has no effect until req_valid and req_ready have met on a clock edge.
- R8: On the clock edge that takes a completion, start returns to 0 and the done flag becomes 1. Status bits 9:7 take cpl_status (0 ok, 1 unsupported, 2 retry, 4 abort), and status bit 0 becomes 1 if the request type had bit 3 set (non-posted), 0 otherwise.
- R9: Read data takes cpl_data when cpl_status is 0 and 0xFFFFFFFF for any other status.
- R10: Writing 1 to done bit 0 clears it and writing 0 leaves it. A completion on the same edge as the clearing write wins.
- R11: irq equals (done AND NOT mask) of the previous clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | REG_AW | Register byte address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Registered read data for reg_addr |
| req_valid | output | 1 | Request offered to link side |
| req_ready | input | 1 | Link side accepts request |
| req_type | output | 4 | Request type code |
| req_addr | output | 2*DATA_W | Request target address |
| req_wdata | output | DATA_W | Request write data |
| req_strb | output | DATA_W/8 | Request byte strobe |
| cpl_valid | input | 1 | Completion beat |
| cpl_status | input | 3 | Completion status code |
| cpl_data | input | DATA_W | Completion data |
| irq | output | 1 | Done interrupt |

## Verification
A start write made on one edge shows req_valid at the next sample point. A completion taken on an edge updates start, done, status and read data on that same edge. Because reading is registered, those values appear on reg_rdata one edge after the address, and irq follows the done flag one edge later. The bench drives stimulus on falling edges and steps a behavioural model on each rising edge from the same inputs. At every falling edge it compares the request outputs, reg_rdata and irq to the model, and it adds directed checks timed to those latencies.

// File: rtl/cfg_pio_pkg.sv
package cfg_pio_pkg;
  localparam int TYPE_W = 4;
  localparam int CST_W  = 3;

  // register byte offsets
  localparam int OFS_CTRL  = 'h00;
  localparam int OFS_STAT  = 'h04;
  localparam int OFS_ALO   = 'h08;
  localparam int OFS_AHI   = 'h0C;
  localparam int OFS_WDAT  = 'h10;
  localparam int OFS_STRB  = 'h14;
  localparam int OFS_RDAT  = 'h18;
  localparam int OFS_START = 'h1C;
  localparam int OFS_DONE  = 'h20;
  localparam int OFS_MASK  = 'h24;

  // field positions that software decodes
  localparam int CTRL_WIN_BIT = 24;
  localparam int ST_CODE_LSB  = 7;
  localparam int ST_NP_BIT    = 0;

  localparam logic [CST_W-1:0] CST_OK = 3'd0;

  typedef enum logic [1:0] {SQ_IDLE, SQ_ISSUE, SQ_WAIT} sq_state_e;

  function automatic logic is_cfg(input logic [TYPE_W-1:0] t);
    return t[3:2] == 2'b10;
  endfunction

  function automatic logic is_cfg_rd(input logic [TYPE_W-1:0] t);
    return t[3:1] == 3'b100;
  endfunction
endpackage

// File: rtl/cfg_pio_regs.sv
module cfg_pio_regs
  import cfg_pio_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int REG_AW = 6
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 reg_we,
  input  logic [REG_AW-1:0]    reg_addr,
  input  logic [DATA_W-1:0]    reg_wdata,
  output logic [DATA_W-1:0]    reg_rdata,
  output logic                 irq,
  output logic [TYPE_W-1:0]    ctl_type,
  output logic                 ctl_win,
  output logic [DATA_W-1:0]    adr_lo,
  output logic [DATA_W-1:0]    adr_hi,
  output logic [DATA_W-1:0]    wdat,
  output logic [DATA_W/8-1:0]  strb,
  output logic                 start_wr,
  output logic                 done_q,
  output logic                 mask_q,
  input  logic                 busy,
  input  logic                 done_set,
  input  logic [CST_W-1:0]     st_code,
  input  logic                 st_np,
  input  logic [DATA_W-1:0]    rdat
);
  localparam int STRB_W = DATA_W / 8;

  function automatic logic hit(input logic [REG_AW-1:0] a, input int ofs);
    return a == REG_AW'(ofs);
  endfunction

  logic wr_ctrl, wr_alo, wr_ahi, wr_wdat, wr_strb, wr_done, wr_mask;
  assign wr_ctrl  = reg_we && hit(reg_addr, OFS_CTRL);
  assign wr_alo   = reg_we && hit(reg_addr, OFS_ALO);
  assign wr_ahi   = reg_we && hit(reg_addr, OFS_AHI);
  assign wr_wdat  = reg_we && hit(reg_addr, OFS_WDAT);
  assign wr_strb  = reg_we && hit(reg_addr, OFS_STRB);
  assign wr_done  = reg_we && hit(reg_addr, OFS_DONE);
  assign wr_mask  = reg_we && hit(reg_addr, OFS_MASK);
  assign start_wr = reg_we && hit(reg_addr, OFS_START) && reg_wdata[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_type <= '0;
      ctl_win  <= 1'b0;
      adr_lo   <= '0;
      adr_hi   <= '0;
      wdat     <= '0;
      strb     <= '0;
      mask_q   <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        ctl_type <= reg_wdata[TYPE_W-1:0];
        ctl_win  <= reg_wdata[CTRL_WIN_BIT];
      end
      if (wr_alo)  adr_lo <= reg_wdata;
      if (wr_ahi)  adr_hi <= reg_wdata;
      if (wr_wdat) wdat   <= reg_wdata;
      if (wr_strb) strb   <= reg_wdata[STRB_W-1:0];
      if (wr_mask) mask_q <= reg_wdata[0];
      // completion has priority over a clearing write
      if (done_set)                    done_q <= 1'b1;
      else if (wr_done && reg_wdata[0]) done_q <= 1'b0;
    end
  end

  logic [DATA_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (hit(reg_addr, OFS_CTRL)) begin
      rd_mux[TYPE_W-1:0]   = ctl_type;
      rd_mux[CTRL_WIN_BIT] = ctl_win;
    end
    if (hit(reg_addr, OFS_STAT)) begin
      rd_mux[ST_CODE_LSB +: CST_W] = st_code;
      rd_mux[ST_NP_BIT]            = st_np;
    end
    if (hit(reg_addr, OFS_ALO))   rd_mux = adr_lo;
    if (hit(reg_addr, OFS_AHI))   rd_mux = adr_hi;
    if (hit(reg_addr, OFS_WDAT))  rd_mux = wdat;
    if (hit(reg_addr, OFS_STRB))  rd_mux[STRB_W-1:0] = strb;
    if (hit(reg_addr, OFS_RDAT))  rd_mux = rdat;
    if (hit(reg_addr, OFS_START)) rd_mux[0] = busy;
    if (hit(reg_addr, OFS_DONE))  rd_mux[0] = done_q;
    if (hit(reg_addr, OFS_MASK))  rd_mux[0] = mask_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
      irq       <= 1'b0;
    end else begin
      reg_rdata <= rd_mux;
      irq       <= done_q && !mask_q;
    end
  end
endmodule

// File: rtl/cfg_pio_shaper.sv
module cfg_pio_shaper
  import cfg_pio_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [TYPE_W-1:0]   typ,
  input  logic [DATA_W-1:0]   adr_lo,
  input  logic [DATA_W-1:0]   adr_hi,
  input  logic [DATA_W/8-1:0] strb_in,
  output logic [2*DATA_W-1:0] adr_out,
  output logic [DATA_W/8-1:0] strb_out
);
  localparam int STRB_W = DATA_W / 8;
  localparam int OFS_W  = $clog2(STRB_W);

  always_comb begin
    adr_out = {adr_hi, adr_lo};
    if (is_cfg(typ)) begin
      adr_out[2*DATA_W-1:DATA_W] = '0;
      adr_out[OFS_W-1:0]         = '0;
    end
    strb_out = is_cfg_rd(typ) ? {STRB_W{1'b1}} : strb_in;
  end
endmodule

// File: rtl/cfg_pio_seq.sv
module cfg_pio_seq
  import cfg_pio_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start_wr,
  input  logic [TYPE_W-1:0]    typ_in,
  input  logic [2*DATA_W-1:0]  adr_in,
  input  logic [DATA_W-1:0]    wdat_in,
  input  logic [DATA_W/8-1:0]  strb_in,
  output logic                 req_valid,
  input  logic                 req_ready,
  output logic [TYPE_W-1:0]    req_type,
  output logic [2*DATA_W-1:0]  req_addr,
  output logic [DATA_W-1:0]    req_wdata,
  output logic [DATA_W/8-1:0]  req_strb,
  input  logic                 cpl_valid,
  input  logic [CST_W-1:0]     cpl_status,
  input  logic [DATA_W-1:0]    cpl_data,
  output logic                 busy,
  output logic                 in_wait,
  output logic                 done_set,
  output logic [CST_W-1:0]     st_code,
  output logic                 st_np,
  output logic [DATA_W-1:0]    rdat
);
  sq_state_e state;

  assign req_valid = (state == SQ_ISSUE);
  assign in_wait   = (state == SQ_WAIT);
  assign busy      = (state != SQ_IDLE);
  assign done_set  = in_wait && cpl_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= SQ_IDLE;
      req_type  <= '0;
      req_addr  <= '0;
      req_wdata <= '0;
      req_strb  <= '0;
      st_code   <= '0;
      st_np     <= 1'b0;
      rdat      <= '0;
    end else begin
      unique case (state)
        SQ_IDLE: if (start_wr) begin
          req_type  <= typ_in;
          req_addr  <= adr_in;
          req_wdata <= wdat_in;
          req_strb  <= strb_in;
          state     <= SQ_ISSUE;
        end
        SQ_ISSUE: if (req_ready) state <= SQ_WAIT;
        SQ_WAIT: if (cpl_valid) begin
          st_code <= cpl_status;
          st_np   <= req_type[3];
          rdat    <= (cpl_status == CST_OK) ? cpl_data : {DATA_W{1'b1}};
          state   <= SQ_IDLE;
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cfg_pio_engine.sv
module cfg_pio_engine
  import cfg_pio_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int REG_AW = 6
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 reg_we,
  input  logic [REG_AW-1:0]    reg_addr,
  input  logic [DATA_W-1:0]    reg_wdata,
  output logic [DATA_W-1:0]    reg_rdata,
  output logic                 req_valid,
  input  logic                 req_ready,
  output logic [3:0]           req_type,
  output logic [2*DATA_W-1:0]  req_addr,
  output logic [DATA_W-1:0]    req_wdata,
  output logic [DATA_W/8-1:0]  req_strb,
  input  logic                 cpl_valid,
  input  logic [2:0]           cpl_status,
  input  logic [DATA_W-1:0]    cpl_data,
  output logic                 irq
);
  localparam int STRB_W = DATA_W / 8;

  logic [TYPE_W-1:0]   ctl_type;
  logic                ctl_win;
  logic [DATA_W-1:0]   adr_lo, adr_hi, wdat, rdat;
  logic [STRB_W-1:0]   strb, strb_shaped;
  logic [2*DATA_W-1:0] adr_shaped;
  logic                start_wr, done_q, mask_q, busy, in_wait, done_set, st_np;
  logic [CST_W-1:0]    st_code;

  cfg_pio_regs #(.DATA_W(DATA_W), .REG_AW(REG_AW)) u_regs (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .ctl_type(ctl_type), .ctl_win(ctl_win), .adr_lo(adr_lo), .adr_hi(adr_hi),
    .wdat(wdat), .strb(strb), .start_wr(start_wr), .done_q(done_q),
    .mask_q(mask_q), .busy(busy), .done_set(done_set), .st_code(st_code),
    .st_np(st_np), .rdat(rdat)
  );

  cfg_pio_shaper #(.DATA_W(DATA_W)) u_shape (
    .typ(ctl_type), .adr_lo(adr_lo), .adr_hi(adr_hi), .strb_in(strb),
    .adr_out(adr_shaped), .strb_out(strb_shaped)
  );

  cfg_pio_seq #(.DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst(rst), .start_wr(start_wr), .typ_in(ctl_type),
    .adr_in(adr_shaped), .wdat_in(wdat), .strb_in(strb_shaped),
    .req_valid(req_valid), .req_ready(req_ready), .req_type(req_type),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_strb(req_strb),
    .cpl_valid(cpl_valid), .cpl_status(cpl_status), .cpl_data(cpl_data),
    .busy(busy), .in_wait(in_wait), .done_set(done_set), .st_code(st_code),
    .st_np(st_np), .rdat(rdat)
  );
endmodule

// File: rtl/cfg_pio_engine_chk.sv
module cfg_pio_engine_chk #(
  parameter int DATA_W = 32
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 req_valid,
  input logic                 req_ready,
  input logic [3:0]           req_type,
  input logic [2*DATA_W-1:0]  req_addr,
  input logic [DATA_W-1:0]    req_wdata,
  input logic [DATA_W/8-1:0]  req_strb,
  input logic                 cpl_valid,
  input logic                 irq,
  input logic                 done_bit,
  input logic                 mask_bit,
  input logic                 busy,
  input logic                 in_wait
);
  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid && !req_ready |=> req_valid && $stable(req_type) &&
      $stable(req_addr) && $stable(req_wdata) && $stable(req_strb));

  // R4
  cfg_addr_form_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_type[3:2] == 2'b10 |->
      req_addr[1:0] == 2'b00 && req_addr[2*DATA_W-1:DATA_W] == '0);

  // R5
  rd_strobe_full_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_type[3:1] == 3'b100 |-> req_strb == '1);

  // R6
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    busy && !(in_wait && cpl_valid) |=> busy);

  // R7
  early_cpl_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid && !req_ready |=> busy && !in_wait || req_valid);

  // R8
  cpl_finish_chk: assert property (@(posedge clk) disable iff (rst)
    in_wait && cpl_valid |=> done_bit && !busy);

  // R11
  irq_raise_chk: assert property (@(posedge clk) disable iff (rst)
    done_bit && !mask_bit |=> irq);

  // R11
  irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !(done_bit && !mask_bit) |=> !irq);
endmodule

bind cfg_pio_engine cfg_pio_engine_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .req_type(req_type), .req_addr(req_addr), .req_wdata(req_wdata),
  .req_strb(req_strb), .cpl_valid(cpl_valid), .irq(irq),
  .done_bit(done_q), .mask_bit(mask_q), .busy(busy), .in_wait(in_wait)
);

// File: tb/cfg_pio_engine_tb.sv
`timescale 1ns/1ps
module cfg_pio_engine_tb;
  localparam int DW = 32;
  localparam int AW = 6;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          reg_we = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic          req_valid;
  logic          req_ready = 1'b0;
  logic [3:0]    req_type;
  logic [63:0]   req_addr;
  logic [DW-1:0] req_wdata;
  logic [3:0]    req_strb;
  logic          cpl_valid = 1'b0;
  logic [2:0]    cpl_status = '0;
  logic [DW-1:0] cpl_data = '0;
  logic          irq;

  always #2.5 clk = ~clk;

  cfg_pio_engine #(.DATA_W(DW), .REG_AW(AW)) u_dut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_valid(req_valid),
    .req_ready(req_ready), .req_type(req_type), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_strb(req_strb), .cpl_valid(cpl_valid),
    .cpl_status(cpl_status), .cpl_data(cpl_data), .irq(irq)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act %h exp %h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [3:0]  m_type;  logic m_win;
  logic [31:0] m_alo, m_ahi, m_wd, m_rdat;
  logic [3:0]  m_strb;
  logic        m_msk, m_done, m_np, m_irq;
  logic [2:0]  m_st;
  int          m_state;   // 0 idle, 1 offering, 2 awaiting completion
  logic [3:0]  q_type;  logic [63:0] q_addr;  logic [31:0] q_wd;  logic [3:0] q_strb;
  logic [31:0] m_rd_out;

  function automatic logic [31:0] mread(input logic [AW-1:0] a);
    case (a)
      6'h00: return ({31'b0, m_win} << 24) | {28'b0, m_type};
      6'h04: return {22'b0, m_st, 6'b0, m_np};
      6'h08: return m_alo;
      6'h0C: return m_ahi;
      6'h10: return m_wd;
      6'h14: return {28'b0, m_strb};
      6'h18: return m_rdat;
      6'h1C: return {31'b0, m_state != 0};
      6'h20: return {31'b0, m_done};
      6'h24: return {31'b0, m_msk};
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk) begin
    logic fin, clr;
    if (rst) begin
      m_type = 0; m_win = 0; m_alo = 0; m_ahi = 0; m_wd = 0; m_rdat = 0;
      m_strb = 0; m_msk = 0; m_done = 0; m_np = 0; m_irq = 0; m_st = 0;
      m_state = 0; q_type = 0; q_addr = 0; q_wd = 0; q_strb = 0; m_rd_out = 0;
    end else begin
      m_rd_out = mread(reg_addr);
      m_irq = m_done & ~m_msk;
      fin = (m_state == 2) && cpl_valid;
      clr = reg_we && reg_addr == 6'h20 && reg_wdata[0];
      if (m_state == 0 && reg_we && reg_addr == 6'h1C && reg_wdata[0]) begin
        q_type = m_type;
        q_addr = (m_type >= 4'h8 && m_type <= 4'hB) ? {32'h0, m_alo & 32'hFFFF_FFFC}
                                                     : {m_ahi, m_alo};
        q_strb = (m_type == 4'h8 || m_type == 4'h9) ? 4'hF : m_strb;
        q_wd   = m_wd;
        m_state = 1;
      end else if (m_state == 1 && req_ready) begin
        m_state = 2;
      end else if (fin) begin
        m_st = cpl_status;
        m_np = q_type[3];
        m_rdat = (cpl_status == 0) ? cpl_data : 32'hFFFF_FFFF;
        m_state = 0;
      end
      if (reg_we) begin
        case (reg_addr)
          6'h00: begin m_type = reg_wdata[3:0]; m_win = reg_wdata[24]; end
          6'h08: m_alo = reg_wdata;
          6'h0C: m_ahi = reg_wdata;
          6'h10: m_wd = reg_wdata;
          6'h14: m_strb = reg_wdata[3:0];
          6'h24: m_msk = reg_wdata[0];
          default: ;
        endcase
      end
      if (fin) m_done = 1'b1;
      else if (clr) m_done = 1'b0;
    end
  end

  always @(negedge clk) begin
    if (!rst && !finished) begin
      chk(req_valid == (m_state == 1), "R3 model req_valid", 64'(req_valid), 64'(m_state == 1));
      if (m_state == 1) begin
        chk(req_type == q_type, "R3 model req_type", 64'(req_type), 64'(q_type));
        chk(req_addr == q_addr, "R4 model req_addr", req_addr, q_addr);
        chk(req_wdata == q_wd, "R5 model req_wdata", 64'(req_wdata), 64'(q_wd));
        chk(req_strb == q_strb, "R5 model req_strb", 64'(req_strb), 64'(q_strb));
      end
      chk(reg_rdata == m_rd_out, "R2 model reg_rdata", 64'(reg_rdata), 64'(m_rd_out));
      chk(irq == m_irq, "R11 model irq", 64'(irq), 64'(m_irq));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_chk(input logic [AW-1:0] a, input logic [31:0] exp, input string tag);
    reg_addr = a;
    @(negedge clk);
    chk(reg_rdata == exp, tag, 64'(reg_rdata), 64'(exp));
  endtask

  task automatic accept();
    req_ready = 1'b1;
    @(negedge clk);
    req_ready = 1'b0;
  endtask

  task automatic complete(input logic [2:0] s, input logic [31:0] d);
    cpl_valid = 1'b1; cpl_status = s; cpl_data = d;
    @(negedge clk);
    cpl_valid = 1'b0;
  endtask

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !finished) begin
      finished = 1'b1;
      errors++; checks++;
      $display("FAIL R3 watchdog act %0d exp below 20000", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk(req_valid == 1'b0, "R1 req_valid", 64'(req_valid), 0);
    chk(irq == 1'b0, "R1 irq", 64'(irq), 0);
    rd_chk(6'h00, 0, "R1 ctrl");
    rd_chk(6'h04, 0, "R1 status");
    rd_chk(6'h18, 0, "R1 rdata");
    rd_chk(6'h1C, 0, "R1 start");
    rd_chk(6'h20, 0, "R1 done");

    // R2 register readback and field widths
    wr(6'h00, 32'hFFFF_FFFF);
    rd_chk(6'h00, 32'h0100_000F, "R2 ctrl keeps bits 3:0 and 24");
    wr(6'h14, 32'h0000_00FF);
    rd_chk(6'h14, 32'h0000_000F, "R2 strobe width");
    wr(6'h24, 32'h3);
    rd_chk(6'h24, 32'h1, "R2 mask bit");
    wr(6'h24, 32'h0);
    rd_chk(6'h02, 32'h0, "R2 misaligned reads zero");

    // config read type 0: bus 3 dev 5 fn 2 reg 0x44 with stray low bits
    wr(6'h00, 32'h0000_0008);
    wr(6'h08, (32'd3 << 20) | (32'd5 << 15) | (32'd2 << 12) | 32'h47);
    wr(6'h0C, 32'h0000_DEAD);
    wr(6'h14, 32'h3);
    wr(6'h10, 32'h1111_2222);
    wr(6'h1C, 32'h1);
    chk(req_valid == 1'b1, "R3 req_valid after start", 64'(req_valid), 1);
    chk(req_type == 4'h8, "R3 req_type", 64'(req_type), 8);
    chk(req_addr == {32'h0, (32'd3 << 20) | (32'd5 << 15) | (32'd2 << 12) | 32'h44},
        "R4 cfg address form", req_addr,
        {32'h0, (32'd3 << 20) | (32'd5 << 15) | (32'd2 << 12) | 32'h44});
    chk(req_strb == 4'hF, "R5 read strobe full", 64'(req_strb), 64'hF);
    repeat (2) @(negedge clk);
    chk(req_valid == 1'b1, "R3 held without ready", 64'(req_valid), 1);
    rd_chk(6'h1C, 32'h1, "R3 start reads 1 in flight");

    // R7 completion before handshake is ignored
    complete(3'd0, 32'hBAD0_BAD0);
    chk(req_valid == 1'b1, "R7 early completion ignored", 64'(req_valid), 1);
    rd_chk(6'h20, 32'h0, "R7 done not set by early completion");

    // R6 start writes and register writes in flight
    wr(6'h1C, 32'h0);
    rd_chk(6'h1C, 32'h1, "R6 start 0 ignored");
    wr(6'h08, 32'h0000_0100);
    chk(req_addr[31:0] == ((32'd3 << 20) | (32'd5 << 15) | (32'd2 << 12) | 32'h44),
        "R6 addr unchanged in flight", 64'(req_addr[31:0]),
        64'((32'd3 << 20) | (32'd5 << 15) | (32'd2 << 12) | 32'h44));
    accept();
    chk(req_valid == 1'b0, "R3 dropped after accept", 64'(req_valid), 0);
    wr(6'h1C, 32'h1);
    chk(req_valid == 1'b0, "R6 start 1 in flight ignored", 64'(req_valid), 0);

    // R8 R9 successful completion
    complete(3'd0, 32'h1234_5678);
    rd_chk(6'h1C, 32'h0, "R8 start clears");
    rd_chk(6'h20, 32'h1, "R8 done set");
    rd_chk(6'h04, 32'h0000_0001, "R8 status ok non-posted");
    rd_chk(6'h18, 32'h1234_5678, "R9 read data");
    chk(irq == 1'b1, "R11 irq unmasked", 64'(irq), 1);
    chk(req_valid == 1'b0, "R6 no second request", 64'(req_valid), 0);

    // R10 clear semantics
    wr(6'h20, 32'h0);
    rd_chk(6'h20, 32'h1, "R10 write 0 keeps done");
    wr(6'h20, 32'h1);
    rd_chk(6'h20, 32'h0, "R10 write 1 clears done");
    chk(irq == 1'b0, "R11 irq follows clear", 64'(irq), 0);

    // config write type 1 with byte offset 2, unsupported request
    wr(6'h00, 32'h0000_000B);
    wr(6'h08, (32'd1 << 20) | 32'h12);
    wr(6'h14, 32'hC);
    wr(6'h10, 32'hABCD_0000);
    wr(6'h1C, 32'h1);
    chk(req_strb == 4'hC, "R5 write strobe passes", 64'(req_strb), 64'hC);
    chk(req_wdata == 32'hABCD_0000, "R5 write data passes", 64'(req_wdata), 64'hABCD_0000);
    chk(req_addr == {32'h0, (32'd1 << 20) | 32'h10}, "R4 write address aligned",
        req_addr, {32'h0, (32'd1 << 20) | 32'h10});
    accept();
    complete(3'd1, 32'h0000_0055);
    rd_chk(6'h04, 32'h0000_0081, "R8 status unsupported");
    rd_chk(6'h18, 32'hFFFF_FFFF, "R9 all ones on error");
    wr(6'h20, 32'h1);

    // non-config type with window bypass, masked, abort, clear collides
    wr(6'h24, 32'h1);
    wr(6'h00, 32'h0100_0002);
    wr(6'h0C, 32'h0000_0001);
    wr(6'h08, 32'h0000_1003);
    wr(6'h14, 32'h5);
    wr(6'h1C, 32'h1);
    chk(req_addr == 64'h0000_0001_0000_1003, "R4 non-config address passes",
        req_addr, 64'h0000_0001_0000_1003);
    chk(req_strb == 4'h5, "R5 non-config strobe", 64'(req_strb), 64'h5);
    accept();
    reg_we = 1'b1; reg_addr = 6'h20; reg_wdata = 32'h1;
    complete(3'd4, 32'h0);
    reg_we = 1'b0;
    rd_chk(6'h20, 32'h1, "R10 completion wins over clear");
    rd_chk(6'h04, 32'h0000_0200, "R8 status abort posted");
    chk(irq == 1'b0, "R11 irq masked", 64'(irq), 0);
    wr(6'h24, 32'h0);
    chk(irq == 1'b0, "R11 irq one cycle after unmask", 64'(irq), 0);
    @(negedge clk);
    chk(irq == 1'b1, "R11 irq after unmask", 64'(irq), 1);
    wr(6'h20, 32'h1);

    // config read type 1, retry status
    wr(6'h00, 32'h0000_0009);
    wr(6'h1C, 32'h1);
    chk(req_type == 4'h9, "R3 type 1 read", 64'(req_type), 9);
    accept();
    repeat (3) @(negedge clk);
    rd_chk(6'h1C, 32'h1, "R6 waits for completion");
    complete(3'd2, 32'h7777_7777);
    rd_chk(6'h04, 32'h0000_0101, "R8 status retry");
    rd_chk(6'h18, 32'hFFFF_FFFF, "R9 retry gives all ones");

    repeat (2) @(negedge clk);
    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule